// File: doc/BRIEF.md
# Serial Debug Register Access Port

This block is the data-register side of a test-access debug path. A 38-bit serial frame is clocked in on the test clock. The frame carries a direction flag, a 5-bit register index and a 32-bit data word. When the update strobe arrives, the block carries out one access on a bank of up to 32 registers of 32 bits each. A write sends the data word to the addressed register. A read fetches the addressed register into the data field of the frame, and the next scan shifts that value out.

The TAP state machine is not part of this block. It supplies decoded capture, shift and update strobes, each one test-clock cycle wide, together with two qualifiers: one says this chain is selected, the other says the internal-test instruction is in force. The block responds to the strobes only while both qualifiers are high. The capture strobe clears the record of whether any bit has been shifted, and has no other effect, so a frame survives from one scan to the next.

Top module: `dbg_reg_access_port`

## Requirements
- R1: The frame is 38 bits wide. Bit 37 is the direction flag (1 = write, 0 = read), bits 36..32 are the register index and bits 31..0 are the data word. Each active shift strobe moves the frame one place toward `tdo` and enters `tdi` at bit 37. `tdo` always shows bit 0.
- R2: With a frame held in the register, 38 shifts bring it out on `tdo` unchanged, data bit 0 first and the direction flag last.
- R3: An active capture strobe leaves the frame contents unchanged.
- R4: If at least one bit was shifted since the last capture and the flag is 1, the update strobe produces a write. In the cycle after the update edge, `reg_wr` is high, `reg_addr` equals bits 36..32 and `reg_wdata` equals bits 31..0.
- R5: If at least one bit was shifted since the last capture and the flag is 0, the update strobe produces a read. In the cycle after the update edge, `reg_rd` is high and `reg_addr` equals bits 36..32. `reg_rdata` is loaded into bits 31..0 at the end of that cycle. Bits 37..32 are kept.
- R6: An update strobe with no shift since the last capture (or since the previous update) makes no access, and it leaves the frame unchanged.
- R7: While `chain_sel` or `intest_on` is low, all three strobes are ignored. The frame does not change and no access is made.
- R8: During reset, `tdo`, `reg_wr` and `reg_rd` are low and the frame is all zeros.
- R9: `reg_wr` and `reg_rd` are never high together, and each stays high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| chain_sel | input | 1 | This chain is the selected data register |
| intest_on | input | 1 | Internal-test instruction is in force |
| cap_dr | input | 1 | Decoded capture strobe |
| shift_dr | input | 1 | Decoded shift strobe |
| upd_dr | input | 1 | Decoded update strobe |
| tdo | output | 1 | Serial data out (frame bit 0) |
| reg_addr | output | 5 | Register index of the current access |
| reg_wdata | output | 32 | Write data of the last write |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data from the register bank, sampled while `reg_rd` is high |

## Verification
Writes are swept over all 32 indices, with data patterns computed per index (all-ones, all-zeros and a multiplicative hash). This separates index decoding from data routing. All 32 indices are then read back. Every scan also checks the bits shifted out against the frame left by the previous operation, which shows the serial order, that capture leaves the frame alone, and that read data is loaded into the correct field. A write frame left in the register, followed by an update with no shift, and write scans made with either qualifier low, show whether a stale frame or a deselected chain can still cause an access.

// File: rtl/dbg_rap_pkg.sv
package dbg_rap_pkg;
  localparam int unsigned RAP_ADDR_W = 5;
  localparam int unsigned RAP_DATA_W = 32;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/rap_shift_reg.sv
module rap_shift_reg #(
  parameter int unsigned FRAME_W = 38,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               sin,
  input  logic               load_en,
  input  logic [DATA_W-1:0]  load_data,
  output logic [FRAME_W-1:0] q
);
  logic [FRAME_W-1:0] q_nxt;

  // shift has priority; the parallel load only touches the data field
  always_comb begin
    q_nxt = q;
    if (shift_en) begin
      q_nxt = {sin, q[FRAME_W-1:1]};
    end else if (load_en) begin
      q_nxt[DATA_W-1:0] = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift_en || load_en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/rap_access_ctl.sv
module rap_access_ctl
  import dbg_rap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FRAME_W = 1 + ADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               cap,
  input  logic               shift,
  input  logic               upd,
  input  logic [FRAME_W-1:0] frame,
  output acc_kind_e          kind,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  wdata
);
  localparam int unsigned RW_BIT = FRAME_W - 1;

  logic      armed, armed_nxt;
  acc_kind_e kind_nxt;
  logic      go;

  assign go = active && upd && armed;

  always_comb begin
    armed_nxt = armed;
    if (active) begin
      if (cap || upd) armed_nxt = 1'b0;
      if (shift)      armed_nxt = 1'b1;
    end
  end

  always_comb begin
    kind_nxt = ACC_NONE;
    if (go) kind_nxt = frame[RW_BIT] ? ACC_WRITE : ACC_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      kind  <= ACC_NONE;
    end else begin
      armed <= armed_nxt;
      kind  <= kind_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (go) begin
      addr <= frame[RW_BIT-1:DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata <= '0;
    end else if (go && frame[RW_BIT]) begin
      wdata <= frame[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/dbg_reg_access_port.sv
module dbg_reg_access_port
  import dbg_rap_pkg::*;
#(
  parameter int unsigned ADDR_W = RAP_ADDR_W,
  parameter int unsigned DATA_W = RAP_DATA_W
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              chain_sel,
  input  logic              intest_on,
  input  logic              cap_dr,
  input  logic              shift_dr,
  input  logic              upd_dr,
  output logic              tdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;

  logic               act;
  logic [FRAME_W-1:0] sr_q;
  acc_kind_e          kind;

  assign act = chain_sel && intest_on;

  rap_shift_reg #(
    .FRAME_W(FRAME_W),
    .DATA_W (DATA_W)
  ) u_sr (
    .clk      (tck),
    .rst_n    (trst_n),
    .shift_en (act && shift_dr),
    .sin      (tdi),
    .load_en  (kind == ACC_READ),
    .load_data(reg_rdata),
    .q        (sr_q)
  );

  rap_access_ctl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W)
  ) u_ctl (
    .clk   (tck),
    .rst_n (trst_n),
    .active(act),
    .cap   (cap_dr),
    .shift (shift_dr),
    .upd   (upd_dr),
    .frame (sr_q),
    .kind  (kind),
    .addr  (reg_addr),
    .wdata (reg_wdata)
  );

  assign tdo    = sr_q[0];
  assign reg_wr = (kind == ACC_WRITE);
  assign reg_rd = (kind == ACC_READ);
endmodule

// File: rtl/dbg_rap_checker.sv
module dbg_rap_checker #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic                       tck,
  input logic                       trst_n,
  input logic                       tdi,
  input logic                       chain_sel,
  input logic                       intest_on,
  input logic                       cap_dr,
  input logic                       shift_dr,
  input logic                       upd_dr,
  input logic                       tdo,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic                       reg_wr,
  input logic                       reg_rd,
  input logic [DATA_W-1:0]          reg_rdata,
  input logic [ADDR_W+DATA_W:0]     sr_q
);
  localparam int unsigned FW = 1 + ADDR_W + DATA_W;

  logic on;
  assign on = chain_sel && intest_on;

  assert_shift_step_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (on && shift_dr) |=> (sr_q == {$past(tdi), $past(sr_q[FW-1:1])}));

  assert_tdo_bit0_R1: assert property (@(posedge tck) disable iff (!trst_n)
    tdo == sr_q[0]);

  assert_capture_keeps_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (on && cap_dr && !shift_dr && !reg_rd) |=> $stable(sr_q));

  assert_write_fields_R4: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(reg_wr) |-> ($past(sr_q[FW-1]) && reg_wdata == $past(sr_q[DATA_W-1:0])
                       && reg_addr == $past(sr_q[FW-2:DATA_W])));

  assert_access_after_update_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (reg_wr || reg_rd) |-> $past(on && upd_dr));

  assert_read_load_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (reg_rd && !(on && shift_dr)) |=> (sr_q[DATA_W-1:0] == $past(reg_rdata)
                                       && $stable(sr_q[FW-1:DATA_W])));

  assert_idle_inactive_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (!on && !reg_rd) |=> ($stable(sr_q) && !reg_wr && !reg_rd));

  assert_excl_R9: assert property (@(posedge tck) disable iff (!trst_n)
    $countones({reg_wr, reg_rd}) <= 1);

  assert_wr_pulse_R9: assert property (@(posedge tck) disable iff (!trst_n)
    reg_wr |=> !reg_wr);

  assert_rd_pulse_R9: assert property (@(posedge tck) disable iff (!trst_n)
    reg_rd |=> !reg_rd);

  always_comb begin
    if (!trst_n) begin
      assert_reset_quiet_R8: assert (!reg_wr && !reg_rd && !tdo);
    end
  end
endmodule

bind dbg_reg_access_port dbg_rap_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .tck      (tck),
  .trst_n   (trst_n),
  .tdi      (tdi),
  .chain_sel(chain_sel),
  .intest_on(intest_on),
  .cap_dr   (cap_dr),
  .shift_dr (shift_dr),
  .upd_dr   (upd_dr),
  .tdo      (tdo),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_rdata(reg_rdata),
  .sr_q     (sr_q)
);

// File: tb/dbg_reg_access_port_bench.sv
module dbg_reg_access_port_bench;
  localparam int FW = 38;

  logic        tck = 1'b0;
  logic        trst_n;
  logic        tdi, chain_sel, intest_on, cap_dr, shift_dr, upd_dr;
  logic        tdo, reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  logic [31:0]   bank [32];
  logic [31:0]   exp_regs [32];
  logic [FW-1:0] exp_sr, fout;
  logic          wr_s, rd_s, wr2, rd2;
  logic [4:0]    a_s;
  logic [31:0]   d_s;
  int            checks = 0;
  int            failures = 0;

  always #10 tck = ~tck;

  dbg_reg_access_port u_dbg_reg_access_port (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .chain_sel(chain_sel), .intest_on(intest_on),
    .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr), .tdo(tdo),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  // register bank model
  assign reg_rdata = bank[reg_addr];
  always @(posedge tck) if (reg_wr) bank[reg_addr] <= reg_wdata;

  function automatic logic [31:0] pat(int a);
    if (a == 0)  return 32'hFFFF_FFFF;
    if (a == 31) return 32'h0000_0000;
    return (32'h9E37_79B9 * 32'(a + 1)) ^ (32'(a) << 27);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [FW-1:0] fin, input bit do_shift);
    @(negedge tck) cap_dr = 1'b1;
    @(negedge tck) cap_dr = 1'b0;
    fout = '0;
    if (do_shift) begin
      for (int i = 0; i < FW; i++) begin
        shift_dr = 1'b1;
        tdi      = fin[i];
        fout[i]  = tdo;
        @(negedge tck);
      end
      shift_dr = 1'b0;
    end
    upd_dr = 1'b1;
    @(negedge tck) upd_dr = 1'b0;
    wr_s = reg_wr; rd_s = reg_rd; a_s = reg_addr; d_s = reg_wdata;
    @(negedge tck);
    wr2 = reg_wr; rd2 = reg_rd;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tdi = 1'b0; chain_sel = 1'b1; intest_on = 1'b1;
    cap_dr = 1'b0; shift_dr = 1'b0; upd_dr = 1'b0;
    repeat (3) @(negedge tck);
    // R8 reset state
    chk(tdo === 1'b0, "R8 tdo", 64'(tdo), 64'd0);
    chk(reg_wr === 1'b0 && reg_rd === 1'b0, "R8 strobes", 64'({reg_wr, reg_rd}), 64'd0);
    trst_n = 1'b1;
    exp_sr = '0;

    // write sweep: R1 R2 R3 R4 R9
    for (int a = 0; a < 32; a++) begin
      logic [FW-1:0] f;
      f = {1'b1, 5'(a), pat(a)};
      scan(f, 1'b1);
      chk(fout === exp_sr, "R2 R3 scan-out", 64'(fout), 64'(exp_sr));
      chk(wr_s === 1'b1 && rd_s === 1'b0, "R4 write strobe", 64'({wr_s, rd_s}), 64'b10);
      chk(a_s === 5'(a), "R4 write index", 64'(a_s), 64'(a));
      chk(d_s === pat(a), "R4 write data", 64'(d_s), 64'(pat(a)));
      chk(wr2 === 1'b0 && rd2 === 1'b0, "R9 single pulse", 64'({wr2, rd2}), 64'd0);
      exp_regs[a] = pat(a);
      exp_sr = f;
    end

    // read sweep: R1 R5 R9
    for (int a = 31; a >= 0; a--) begin
      logic [FW-1:0] f;
      f = {1'b0, 5'(a), 32'hC0DE_0000 | 32'(a)};
      scan(f, 1'b1);
      chk(fout === exp_sr, "R5 R1 scan-out", 64'(fout), 64'(exp_sr));
      chk(rd_s === 1'b1 && wr_s === 1'b0, "R5 read strobe", 64'({wr_s, rd_s}), 64'b01);
      chk(a_s === 5'(a), "R5 read index", 64'(a_s), 64'(a));
      chk(wr2 === 1'b0 && rd2 === 1'b0, "R9 single pulse", 64'({wr2, rd2}), 64'd0);
      exp_sr = {1'b0, 5'(a), exp_regs[a]};
    end

    // R6: write frame left in place, then update without shift
    scan({1'b1, 5'd3, 32'h1234_5678}, 1'b1);
    chk(fout === exp_sr, "R5 last read-out", 64'(fout), 64'(exp_sr));
    exp_regs[3] = 32'h1234_5678;
    exp_sr = {1'b1, 5'd3, 32'h1234_5678};
    scan('0, 1'b0);
    chk(wr_s === 1'b0 && rd_s === 1'b0, "R6 no access", 64'({wr_s, rd_s}), 64'd0);
    bank[3] = 32'hFFFF_0000;  // a repeated write would restore 12345678
    exp_regs[3] = 32'hFFFF_0000;

    // R7: deselected chain, then instruction not in force
    chain_sel = 1'b0;
    scan({1'b1, 5'd3, 32'hDEAD_BEEF}, 1'b1);
    chk(wr_s === 1'b0 && rd_s === 1'b0, "R7 chain_sel low", 64'({wr_s, rd_s}), 64'd0);
    chain_sel = 1'b1; intest_on = 1'b0;
    scan({1'b1, 5'd3, 32'hDEAD_BEEF}, 1'b1);
    chk(wr_s === 1'b0 && rd_s === 1'b0, "R7 intest_on low", 64'({wr_s, rd_s}), 64'd0);
    intest_on = 1'b1;

    scan({1'b0, 5'd3, 32'h0}, 1'b1);
    chk(fout === exp_sr, "R7 R6 frame kept", 64'(fout), 64'(exp_sr));
    exp_sr = {1'b0, 5'd3, exp_regs[3]};
    scan({1'b0, 5'd0, 32'h0}, 1'b1);
    chk(fout === exp_sr, "R6 R7 register untouched", 64'(fout), 64'(exp_sr));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule